// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer and Memory Window Decoder

This block connects the expanded bus of an 8-bit controller to byte-wide memories. The controller drives the upper address byte on its own lines. The lower address byte and the data byte share eight lines. The lower byte is present while the bus clock is low, and data is present while it is high. The block runs on a fast local clock. It passes the bus clock, the address strobe and the read/write line through two-flop synchronisers. It aligns the address lines through an equal delay. While the strobe is high it captures the lower address byte, and it holds that byte for the rest of the bus cycle.

The 16-bit address is compared against three memory windows, and each window has its own active-low chip select. Two 2K windows are fully decoded. The third window, a 512-byte device, ignores two address bits, so each of its locations appears at four addresses. Selects and strobes appear only while the synchronised bus clock is high. A read that hits a window turns on the drive of memory data back onto the shared lines. Every transfer finishes within one bus-clock cycle, and there is no wait-state input. The shared lines are modelled as separate in, out and output-enable signals.

Top module: `mbus_demux_top`

## Requirements
- R1: After reset, all chip selects, the output-enable strobe and the write-enable strobe are high (inactive), and the host drive enable `host_oe` is low.
- R2: The low address byte on `ad_in` is captured while `bus_as` is high. It is held after `bus_as` falls and stays held after the shared lines switch to data. `mem_addr` therefore reflects the address and not the data during the high phase.
- R3: While `bus_e` is low, no chip select, no strobe and no `host_oe` is asserted.
- R4: Addresses 0x5000–0x57FF (A15..A11 = 01010) assert `cs_n[0]`, and addresses 0x6800–0x6FFF (A15..A11 = 01101) assert `cs_n[1]`. For these windows `mem_addr` = A10..A0. At most one select is low at any time.
- R5: Addresses 0x5800–0x5FFF (A15..A11 = 01011) assert `cs_n[2]`, with `mem_addr` = {00, A8..A0}. A9 and A10 have no effect, so for example 0x5801 and 0x5E01 reach the same location.
- R6: An address outside all three windows asserts no chip select, and `host_oe` stays low even on a read.
- R7: During the high phase of a write (`bus_rw` = 0), `we_n` is low and `oe_n` is high, and `mem_wdata` carries the byte the master drives on `ad_in`.
- R8: During the high phase of a read (`bus_rw` = 1) that hits a window, `oe_n` is low, `we_n` is high, `host_oe` is high and `host_dout` carries the selected memory byte.
- R9: Within three local clock cycles after `bus_e` falls, all selects and strobes return high and `host_oe` returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_e | input | 1 | Bus clock from the master (asynchronous) |
| bus_as | input | 1 | Address strobe, high while the low address byte is valid |
| bus_rw | input | 1 | 1 = read, 0 = write |
| addr_hi | input | 8 | Dedicated upper address byte A15..A8 |
| ad_in | input | 8 | Shared lines as driven by the master (address, then write data) |
| host_dout | output | 8 | Read data driven back onto the shared lines |
| host_oe | output | 1 | Drive enable for `host_dout` toward the master |
| mem_rdata | input | 8 | Byte returned by the selected memory |
| mem_addr | output | 11 | Offset inside the selected window |
| mem_wdata | output | 8 | Write byte toward the memories |
| cs_n | output | 3 | Active-low chip selects, one for each window |
| oe_n | output | 1 | Active-low memory output enable |
| we_n | output | 1 | Active-low memory write enable |

## Verification
A corrupted address latch shows up as a wrong `mem_addr` or a wrong select during the high phase of the same bus cycle. It then shows as wrong read-back data on a later read of that location. A decode fault asserts the wrong `cs_n` bit, or asserts one on a miss, within three local clocks of the bus clock rising. A stuck strobe or drive enable is seen in the low phase that follows. The bench writes bytes through the memory model and reads them back through aliases, so a bad write path appears only on the later read.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int NWIN    = 3;
  localparam int TAG_LSB = 11;
  localparam int TAG_W   = ADDR_W - TAG_LSB;
  localparam int OFS_W   = TAG_LSB;
  // window tags on A15..A11: full 2K, full 2K, aliased 512
  localparam int WIN_TAG [NWIN] = '{'h0A, 'h0D, 'h0B};
  // number of address bits that reach each device
  localparam int WIN_OFS [NWIN] = '{11, 11, 9};
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch
  import mbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_s,
  input  logic [DATA_W-1:0] ad_s,
  input  logic [DATA_W-1:0] hi_s,
  output logic [ADDR_W-1:0] addr
);
  logic [DATA_W-1:0] lo_q;

  // transparent while strobe high, frozen otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lo_q <= '0;
    else if (as_s) lo_q <= ad_s;
  end

  assign addr = {hi_s, lo_q};

  a_r2_low_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    !as_s |=> $stable(lo_q));
endmodule

// File: rtl/mbus_win_decode.sv
module mbus_win_decode
  import mbus_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic [NWIN-1:0]   hit,
  output logic [OFS_W-1:0]  ofs
);
  logic [OFS_W-1:0] part [NWIN];

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam logic [OFS_W-1:0] MASK = OFS_W'((1 << WIN_OFS[i]) - 1);
    assign hit[i]  = (addr[ADDR_W-1:TAG_LSB] == TAG_W'(WIN_TAG[i]));
    assign part[i] = hit[i] ? (addr[OFS_W-1:0] & MASK) : '0;
  end

  always_comb begin
    ofs = '0;
    for (int i = 0; i < NWIN; i++) ofs = ofs | part[i];
  end
endmodule

// File: rtl/mbus_strobe_gen.sv
module mbus_strobe_gen
  import mbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e_s,
  input  logic              rw_s,
  input  logic [NWIN-1:0]   hit,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] ad_s,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [NWIN-1:0]   cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [OFS_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              host_oe,
  output logic [DATA_W-1:0] host_dout
);
  logic rd_hit;
  assign rd_hit = e_s && rw_s && (|hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n      <= '1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      mem_addr  <= '0;
      mem_wdata <= '0;
      host_oe   <= 1'b0;
      host_dout <= '0;
    end else begin
      cs_n      <= ~(hit & {NWIN{e_s}});
      oe_n      <= ~(e_s && rw_s);
      we_n      <= ~(e_s && !rw_s);
      mem_addr  <= ofs;
      mem_wdata <= ad_s;
      host_oe   <= rd_hit;
      host_dout <= rd_hit ? mem_rdata : '0;
    end
  end

  a_r3_quiet_when_e_low: assert property (@(posedge clk) disable iff (!rst_n)
    !e_s |=> (&cs_n && oe_n && we_n && !host_oe));
  a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  a_r5_alias_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n[2] |-> (mem_addr[OFS_W-1:9] == '0));
  a_r8_drive_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    host_oe |-> (!oe_n && we_n && !(&cs_n)));
  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);
endmodule

// File: rtl/mbus_demux_top.sv
module mbus_demux_top
  import mbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_e,
  input  logic              bus_as,
  input  logic              bus_rw,
  input  logic [7:0]        addr_hi,
  input  logic [7:0]        ad_in,
  output logic [7:0]        host_dout,
  output logic              host_oe,
  input  logic [7:0]        mem_rdata,
  output logic [10:0]       mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [2:0]        cs_n,
  output logic              oe_n,
  output logic              we_n
);
  logic [2:0]          ctl_s;
  logic [2*DATA_W-1:0] bus_s;
  logic [ADDR_W-1:0]   addr;
  logic [NWIN-1:0]     hit;
  logic [OFS_W-1:0]    ofs;

  // controls: {rw, as, e}; rw idles high (read)
  mbus_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d({bus_rw, bus_as, bus_e}), .q(ctl_s));

  // address/data lines delayed equally so they line up with the controls
  mbus_sync #(.W(2*DATA_W), .STAGES(2), .RST_VAL('0)) u_sync_bus (
    .clk(clk), .rst_n(rst_n), .d({addr_hi, ad_in}), .q(bus_s));

  mbus_addr_latch u_latch (
    .clk(clk), .rst_n(rst_n), .as_s(ctl_s[1]),
    .ad_s(bus_s[DATA_W-1:0]), .hi_s(bus_s[2*DATA_W-1:DATA_W]), .addr(addr));

  mbus_win_decode u_dec (.addr(addr), .hit(hit), .ofs(ofs));

  mbus_strobe_gen u_strb (
    .clk(clk), .rst_n(rst_n), .e_s(ctl_s[0]), .rw_s(ctl_s[2]),
    .hit(hit), .ofs(ofs), .ad_s(bus_s[DATA_W-1:0]), .mem_rdata(mem_rdata),
    .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .host_oe(host_oe), .host_dout(host_dout));
endmodule

// File: tb/mbus_demux_top_tb.sv
module mbus_demux_top_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bus_e = 0, bus_as = 0, bus_rw = 1;
  logic [7:0] addr_hi = 0, ad_in = 0, mem_rdata;
  logic [7:0] host_dout, mem_wdata;
  logic host_oe, oe_n, we_n;
  logic [10:0] mem_addr;
  logic [2:0] cs_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] dev0 [2048];
  logic [7:0] dev1 [2048];
  logic [7:0] dev2 [512];
  logic [7:0] ref0 [2048];
  logic [7:0] ref1 [2048];
  logic [7:0] ref2 [512];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_demux_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_as(bus_as), .bus_rw(bus_rw),
    .addr_hi(addr_hi), .ad_in(ad_in), .host_dout(host_dout), .host_oe(host_oe),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n));

  // memory devices
  always @(posedge clk) begin
    if (!we_n) begin
      if (!cs_n[0]) dev0[mem_addr] <= mem_wdata;
      if (!cs_n[1]) dev1[mem_addr] <= mem_wdata;
      if (!cs_n[2]) dev2[mem_addr[8:0]] <= mem_wdata;
    end
  end
  always_comb begin
    if (!cs_n[0] && !oe_n)      mem_rdata = dev0[mem_addr];
    else if (!cs_n[1] && !oe_n) mem_rdata = dev1[mem_addr];
    else if (!cs_n[2] && !oe_n) mem_rdata = dev2[mem_addr[8:0]];
    else                        mem_rdata = 8'h00;
  end

  function automatic int win_of(logic [15:0] a);
    case (a[15:11])
      5'b01010: return 0;
      5'b01101: return 1;
      5'b01011: return 2;
      default:  return 3;
    endcase
  endfunction

  function automatic logic [10:0] ofs_of(logic [15:0] a);
    return (win_of(a) == 2) ? {2'b00, a[8:0]} : (win_of(a) == 3 ? 11'd0 : a[10:0]);
  endfunction

  function automatic logic [2:0] sel_of(logic [15:0] a);
    int w = win_of(a);
    return (w == 3) ? 3'b111 : ~(3'b001 << w);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_neg(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_cycle(logic [15:0] a, bit wr, logic [7:0] wd);
    int w = win_of(a);
    logic [10:0] o = ofs_of(a);
    logic [7:0] expd;
    bus_e = 0; bus_as = 1; bus_rw = !wr;
    addr_hi = a[15:8]; ad_in = a[7:0];
    wait_neg(6);
    bus_as = 0;
    wait_neg(3);
    // R3: low phase is quiet
    chk("R3 sel/strobe in low phase", {cs_n, oe_n, we_n, host_oe}, 6'b111110);
    bus_e = 1;
    ad_in = wr ? wd : ~a[7:0];
    wait_neg(6);
    // R2/R4/R5/R6: decode with held address
    chk("R2/R4/R5/R6 cs_n", cs_n, sel_of(a));
    if (w != 3) chk("R2/R4/R5 mem_addr", mem_addr, o);
    if (wr) begin
      chk("R7 strobes on write", {oe_n, we_n}, 2'b10);
      chk("R7 write data", mem_wdata, wd);
      chk("R7 no host drive", host_oe, 0);
      case (w)
        0: ref0[o] = wd;
        1: ref1[o] = wd;
        2: ref2[o[8:0]] = wd;
        default: ;
      endcase
    end else begin
      chk("R8 strobes on read", {oe_n, we_n}, 2'b01);
      if (w == 3) chk("R6 no drive on miss", host_oe, 0);
      else begin
        expd = (w == 0) ? ref0[o] : (w == 1) ? ref1[o] : ref2[o[8:0]];
        chk("R8 host_oe", host_oe, 1);
        chk("R8 read data", host_dout, expd);
      end
    end
    bus_e = 0;
    ad_in = $urandom;
    wait_neg(4);
    chk("R9 release after E falls", {cs_n, oe_n, we_n, host_oe}, 6'b111110);
  endtask

  function automatic logic [15:0] pick_addr();
    int r = $urandom_range(0, 9);
    logic [15:0] lo = 16'($urandom);
    case (r)
      0, 1, 2: return {5'b01010, lo[10:0]};
      3, 4, 5: return {5'b01101, lo[10:0]};
      6, 7, 8: return {5'b01011, lo[10:0]};
      default: return lo;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 2048; i++) begin
      dev0[i] = 0; dev1[i] = 0; ref0[i] = 0; ref1[i] = 0;
    end
    for (int i = 0; i < 512; i++) begin dev2[i] = 0; ref2[i] = 0; end
    wait_neg(3);
    // R1: reset state
    chk("R1 reset outputs", {cs_n, oe_n, we_n, host_oe}, 6'b111110);
    rst_n = 1;
    wait_neg(2);
    // directed: window boundaries
    bus_cycle(16'h5000, 1, 8'h11);
    bus_cycle(16'h57FF, 1, 8'h22);
    bus_cycle(16'h6800, 1, 8'h33);
    bus_cycle(16'h6FFF, 1, 8'h44);
    bus_cycle(16'h4FFF, 1, 8'h55);  // R6 miss
    bus_cycle(16'h7000, 0, 8'h00);  // R6 miss read
    bus_cycle(16'h5000, 0, 8'h00);
    bus_cycle(16'h6FFF, 0, 8'h00);
    // R5 aliasing: write one alias, read the other three
    bus_cycle(16'h5801, 1, 8'hC3);
    bus_cycle(16'h5A01, 0, 8'h00);
    bus_cycle(16'h5C01, 0, 8'h00);
    bus_cycle(16'h5E01, 0, 8'h00);
    bus_cycle(16'h5FFF, 1, 8'h7E);
    bus_cycle(16'h59FF, 0, 8'h00);
    // random mix
    for (int i = 0; i < 200; i++) bus_cycle(pick_addr(), bit'($urandom_range(0, 1)), 8'($urandom));
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule